// File: doc/BRIEF.md
# Serial-Load Shift Register with Holding Stage

This block converts a serial bit stream into a parallel word. A chain of shift stages takes one bit on every rising edge of its own shift clock. A separate holding register copies the whole chain in one step on a rising edge of a second clock, the storage clock. Only the holding register drives the parallel outputs, so they stay steady while a new word is shifted in behind them.

The last shift stage is also brought out as a cascade output. It can feed the serial input of a further instance, so several instances form one longer chain. Each side has its own active-low clear. The clears act at once, without any clock, and each clear touches only its own side. The two clocks may be tied together. The holding register then always shows the chain as it stood one pulse earlier.

Top module: `serial_store_reg`

## Requirements
- R1: On each rising edge of `shiftClk`, stage 0 takes `serIn` and each stage k (k ≥ 1) takes the value that stage k-1 held before the edge. No stage inverts its bit.
- R2: `cascadeOut` always equals the last shift stage (stage WIDTH-1). After a shift it therefore shows what stage WIDTH-2 held before that shift.
- R3: On each rising edge of `storeClk`, all WIDTH shift stages are copied in parallel into the holding register. `parOut[k]` shows stage k.
- R4: While `shiftClrN` is low, all shift stages and `cascadeOut` are 0 with no clock needed. The holding register and `parOut` are not changed by it.
- R5: While `storeClrN` is low, the holding register and `parOut` are 0 with no clock needed. The shift stages are not changed by it.
- R6: When `shiftClk` and `storeClk` rise on the same edge, the holding register captures the shift contents as they were just before that edge. It stays one pulse behind the chain.
- R7: While a clear is held low, a rising edge on the clock of that same register has no effect.
- R8: Clearing the shift chain and then giving a `storeClk` edge loads all zeros into `parOut`.
- R9: Two instances can be chained, with `cascadeOut` of the first driving `serIn` of the second. After 2·WIDTH shifts, the first bit shifted in sits in the second instance's last stage. The last bit shifted in sits in stage 0 of the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serIn | input | 1 | Serial data into shift stage 0 |
| shiftClk | input | 1 | Shift clock, rising edge |
| storeClk | input | 1 | Storage (transfer) clock, rising edge |
| shiftClrN | input | 1 | Asynchronous active-low clear of the shift stages |
| storeClrN | input | 1 | Asynchronous active-low clear of the holding register |
| parOut | output | WIDTH | Holding register contents |
| cascadeOut | output | 1 | Last shift stage, for chaining |

## Verification
A wrong bit inside the shift chain shows on `cascadeOut` after the number of shifts needed to carry it to the last stage. It shows on `parOut` at the next `storeClk` edge. A fault in the holding register, or in either clear, shows on `parOut` or `cascadeOut` at once, or at the first edge after the faulty event. The clear-isolation and tied-clock tests therefore read both outputs right after each event.

// File: rtl/srs_pkg.sv
package srs_pkg;
  // Internal strobes passed from control to datapath (active high).
  typedef struct packed {
    logic shiftRst;
    logic storeRst;
  } srsStrobe_t;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic       shiftClrN,
  input  logic       storeClrN,
  output srsStrobe_t strobes
);
  always_comb begin
    strobes.shiftRst = ~shiftClrN;
    strobes.storeRst = ~storeClrN;
  end
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             storeClk,
  input  srsStrobe_t       strobes,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] storeQ
);
  localparam int LAST = WIDTH - 1;

  logic shiftRst;
  logic storeRst;
  logic [WIDTH-1:0] stageIn;

  assign shiftRst = strobes.shiftRst;
  assign storeRst = strobes.storeRst;

  assign stageIn[0] = serIn;

  genvar k;
  generate
    for (k = 1; k <= LAST; k++) begin : g_link
      assign stageIn[k] = shiftQ[k-1];
    end
    for (k = 0; k <= LAST; k++) begin : g_stage
      always_ff @(posedge shiftClk or posedge shiftRst) begin
        if (shiftRst) shiftQ[k] <= 1'b0;
        else          shiftQ[k] <= stageIn[k];
      end
    end
  endgenerate

  always_ff @(posedge storeClk or posedge storeRst) begin
    if (storeRst) storeQ <= '0;
    else          storeQ <= shiftQ;
  end
endmodule

// File: rtl/serial_store_reg.sv
module serial_store_reg
  import srs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             shiftClrN,
  input  logic             storeClrN,
  output logic [WIDTH-1:0] parOut,
  output logic             cascadeOut
);
  srsStrobe_t       strobes;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  srs_ctrl u_ctrl (
    .shiftClrN(shiftClrN),
    .storeClrN(storeClrN),
    .strobes  (strobes)
  );

  srs_datapath #(.WIDTH(WIDTH)) u_dp (
    .serIn   (serIn),
    .shiftClk(shiftClk),
    .storeClk(storeClk),
    .strobes (strobes),
    .shiftQ  (shiftQ),
    .storeQ  (storeQ)
  );

  assign parOut     = storeQ;
  assign cascadeOut = shiftQ[WIDTH-1];
endmodule

// File: rtl/serial_store_reg_chk.sv
module serial_store_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             serIn,
  input logic             shiftClk,
  input logic             storeClk,
  input logic             shiftClrN,
  input logic             storeClrN,
  input logic [WIDTH-1:0] parOut,
  input logic             cascadeOut,
  input logic [WIDTH-1:0] shiftQ
);
  AST_SHIFT_ENTRY: assert property (@(posedge shiftClk) disable iff (!shiftClrN)
    1'b1 |=> shiftQ[0] == $past(serIn)); // R1

  AST_SHIFT_MOVE: assert property (@(posedge shiftClk) disable iff (!shiftClrN)
    1'b1 |=> shiftQ[WIDTH-1:1] == $past(shiftQ[WIDTH-2:0])); // R1

  AST_CASCADE_LAG: assert property (@(posedge shiftClk) disable iff (!shiftClrN)
    1'b1 |=> cascadeOut == $past(shiftQ[WIDTH-2])); // R2

  AST_STORE_COPY: assert property (@(posedge storeClk) disable iff (!storeClrN)
    1'b1 |=> parOut == $past(shiftQ)); // R3

  AST_SHIFT_CLEARED: assert property (@(posedge shiftClk)
    !shiftClrN |-> (cascadeOut == 1'b0 && shiftQ == '0)); // R4

  AST_STORE_CLEARED: assert property (@(posedge storeClk)
    !storeClrN |-> parOut == '0); // R5
endmodule

bind serial_store_reg serial_store_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .serIn     (serIn),
  .shiftClk  (shiftClk),
  .storeClk  (storeClk),
  .shiftClrN (shiftClrN),
  .storeClrN (storeClrN),
  .parOut    (parOut),
  .cascadeOut(cascadeOut),
  .shiftQ    (shiftQ)
);

// File: tb/serial_store_reg_bench.sv
`timescale 1ns/1ps
module serial_store_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic serIn = 1'b0, shiftClk = 1'b0, storeClk = 1'b0;
  logic shiftClrN = 1'b0, storeClrN = 1'b0;
  logic [W-1:0] parLo, parHi;
  logic casLo, casHi;

  serial_store_reg #(.WIDTH(W)) u_serial_store_reg (
    .serIn(serIn), .shiftClk(shiftClk), .storeClk(storeClk),
    .shiftClrN(shiftClrN), .storeClrN(storeClrN),
    .parOut(parLo), .cascadeOut(casLo));

  serial_store_reg #(.WIDTH(W)) u_next (
    .serIn(casLo), .shiftClk(shiftClk), .storeClk(storeClk),
    .shiftClrN(shiftClrN), .storeClrN(storeClrN),
    .parOut(parHi), .cascadeOut(casHi));

  // Reference: low byte = first instance chain, high byte = second.
  logic [2*W-1:0] refChain = '0;
  logic [W-1:0] refLo = '0, refHi = '0;
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, {8'h0, parLo}, {8'h0, refLo});
    chk(req, {8'h0, parHi}, {8'h0, refHi});
    chk(req, {15'h0, casLo}, {15'h0, refChain[W-1]});
    chk(req, {15'h0, casHi}, {15'h0, refChain[2*W-1]});
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serIn = b;
    #2 shiftClk = 1'b1;
    if (shiftClrN) refChain = {refChain[2*W-2:0], b};
    #2 shiftClk = 1'b0;
  endtask

  task automatic storePulse();
    @(negedge clk);
    #2 storeClk = 1'b1;
    if (storeClrN) begin refLo = refChain[W-1:0]; refHi = refChain[2*W-1:W]; end
    #2 storeClk = 1'b0;
  endtask

  task automatic tiedPulse(input logic b);
    @(negedge clk);
    serIn = b;
    #2 begin shiftClk = 1'b1; storeClk = 1'b1; end
    refLo = refChain[W-1:0]; refHi = refChain[2*W-1:W];
    refChain = {refChain[2*W-2:0], b};
    #2 begin shiftClk = 1'b0; storeClk = 1'b0; end
  endtask

  task automatic shiftWord(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) shiftBit(v[i]);
  endtask

  task automatic t_reset();
    shiftClrN = 1'b0; storeClrN = 1'b0;
    refChain = '0; refLo = '0; refHi = '0;
    repeat (2) @(negedge clk);
    #1 checkAll("R4 reset");
    shiftClrN = 1'b1; storeClrN = 1'b1;
  endtask

  task automatic t_shift();
    shiftWord(8'hA5);
    #1 checkAll("R1 shift A5");
    storePulse();
    #1 checkAll("R3 store A5");
    chk("R3 pattern", {8'h0, parLo}, 16'h00A5);
    shiftBit(1'b1);
    #1 checkAll("R2 cascade lag");
    shiftWord(8'h3C);
    storePulse();
    #1 checkAll("R1 shift 3C");
    chk("R1 pattern", {8'h0, parLo}, 16'h003C);
  endtask

  task automatic t_shiftClear();
    shiftWord(8'hFF);
    storePulse();
    @(negedge clk); shiftClrN = 1'b0; refChain = '0;
    #1 checkAll("R4 shift clear isolates storage");
    chk("R4 storage kept", {8'h0, parLo}, 16'h00FF);
    shiftBit(1'b1);
    #1 checkAll("R7 shift clock ignored under clear");
    shiftClrN = 1'b1;
    storePulse();
    #1 checkAll("R8 clear then store gives zero");
    chk("R8 zero", {8'h0, parLo}, 16'h0000);
  endtask

  task automatic t_storeClear();
    shiftWord(8'h96);
    storePulse();
    @(negedge clk); storeClrN = 1'b0; refLo = '0; refHi = '0;
    #1 checkAll("R5 store clear");
    storePulse();
    #1 checkAll("R7 store clock ignored under clear");
    storeClrN = 1'b1;
    storePulse();
    #1 checkAll("R5 shift chain kept");
    chk("R5 pattern", {8'h0, parLo}, 16'h0096);
  endtask

  task automatic t_tied();
    shiftWord(8'h0F);
    tiedPulse(1'b1);
    #1 checkAll("R6 tied clocks lag");
    chk("R6 previous word", {8'h0, parLo}, 16'h000F);
    tiedPulse(1'b0);
    #1 checkAll("R6 tied second pulse");
    chk("R6 one pulse behind", {8'h0, parLo}, 16'h001F);
  endtask

  task automatic t_cascade();
    logic [15:0] word = 16'hC3A1;
    for (int i = 15; i >= 0; i--) shiftBit(word[i]);
    storePulse();
    #1 checkAll("R9 cascade 16-bit");
    chk("R9 word", {parHi, parLo}, word);
  endtask

  initial begin
    t_reset();
    t_shift();
    t_shiftClear();
    t_storeClear();
    t_tied();
    t_cascade();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule